// File: doc/BRIEF.md
# Rank Boundary Address Decoder

This block turns a short configuration stream, one entry per memory module slot, into a set of cumulative end-boundary registers, one per rank. It then maps a physical address onto the rank that holds it. Each module has two sides. The first side becomes the even rank and the second side becomes the odd rank.

For each side, the block derives two values from a few raw geometry numbers: a log2 capacity and a page-size code. A module whose page size falls outside the supported window is dropped and treated as empty. An empty module, or a missing second side, contributes zero capacity. The boundary still carries the running total forward, so the boundary list never decreases.

Once the configuration is loaded, a lookup address is compared against the boundaries. The registered result gives four things: whether the address hit, the rank index, that rank's page-size code, and the rank's base address.

Top module: `rank_boundary_decoder`

## Requirements
- R1: After reset every boundary reads 0, and a lookup of any address reports a miss.
- R2: Configuration entries fill slots in arrival order. Slot i owns rank 2i (first side) and rank 2i+1 (second side). Entries that arrive after NUM_DIMMS slots are filled leave every boundary unchanged.
- R3: A side's log2 size in bits is col + wlog + row + blog. Its size in 32 MB units is 2^(log2 size - 28), and a log2 size below 28 gives 0 units.
- R4: A boundary is the running total of rank sizes through that rank, in 32 MB units, in BND_W bits. The total saturates at 2^BND_W - 1, and boundaries never decrease from rank 0 upward.
- R5: An absent module, or the second side of a single-sided module (cfg_two_sided = 0), repeats the running total, so that rank has zero size. Ranks of slots not yet loaded hold the latest running total.
- R6: The page-size code is col + wlog - 14, giving code 1, 2 or 3 for 4, 8 or 16 KB pages. A present side whose page log2 lies outside 15..17 marks the whole module as absent.
- R7: A rank that is absent or empty has page-size code 7.
- R8: A lookup selects the lowest rank whose boundary is greater than lk_addr[ADDR_W-1:25]. The result appears on the clock edge that follows lk_valid, and res_valid is high exactly in the cycle after a lookup.
- R9: If the address key is at or above every boundary, res_hit is 0, res_rank is 0, res_code is 7 and res_base is 0.
- R10: res_base of a hit is the previous rank's boundary shifted left by 25 bits. Rank 0 has base 0.
- R11: Boundaries change only on a clock edge at which cfg_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | A configuration entry for the next slot is present |
| cfg_present | input | 1 | The slot holds a module |
| cfg_two_sided | input | 1 | The module has a second side |
| cfg_wlog | input | 3 | log2 of module data width |
| cfg_blog | input | 2 | log2 of internal banks per device |
| cfg_col0 | input | 4 | Column bits, first side |
| cfg_row0 | input | 4 | Row bits, first side |
| cfg_col1 | input | 4 | Column bits, second side |
| cfg_row1 | input | 4 | Row bits, second side |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Physical address to decode |
| bnd_flat | output | NUM_RANKS*BND_W | Boundaries; rank r at bits [r*BND_W +: BND_W] |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | Address falls within a rank |
| res_rank | output | RANK_W | Selected rank index |
| res_code | output | 3 | Page-size code of the selected rank |
| res_base | output | ADDR_W | Start address of the selected rank |

## Verification
On every cycle the assertions check four things. Boundaries never decrease across ranks. Boundaries stay still while no configuration entry arrives. A result is valid exactly one cycle after a lookup. A miss returns the fixed miss values, and a hit always carries a supported page code. The arithmetic itself can only be shown by the bench's scenarios: the geometry sums, saturation, module rejection on page size, missing second sides and the exact rank selected near each boundary. The bench compares these against values worked out by hand.

// File: rtl/rbd_pkg.sv
package rbd_pkg;
    localparam int COL_W      = 4;
    localparam int ROW_W      = 4;
    localparam int WLOG_W     = 3;
    localparam int BLOG_W     = 2;
    localparam int LOG_W      = 6;
    localparam int CODE_W     = 3;
    localparam int PAGE_BASE  = 14;
    localparam int PAGE_MIN   = 15;
    localparam int PAGE_MAX   = 17;
    localparam int SIZE_BASE  = 28;
    localparam logic [CODE_W-1:0] CODE_EMPTY = 3'd7;

    typedef struct packed {
        logic [COL_W-1:0] col;
        logic [ROW_W-1:0] row;
    } side_geom_t;
endpackage

// File: rtl/rbd_side_calc.sv
module rbd_side_calc
    import rbd_pkg::*;
#(
    parameter int BND_W = 8
) (
    input  side_geom_t          geom,
    input  logic [WLOG_W-1:0]   wlog,
    input  logic [BLOG_W-1:0]   blog,
    output logic                page_ok,
    output logic [CODE_W-1:0]   page_code,
    output logic [BND_W:0]      units
);
    logic [LOG_W-1:0] page_log;
    logic [LOG_W-1:0] size_log;
    logic [LOG_W-1:0] exp_v;

    always_comb begin
        page_log  = LOG_W'(geom.col) + LOG_W'(wlog);
        size_log  = page_log + LOG_W'(geom.row) + LOG_W'(blog);
        page_ok   = (page_log >= LOG_W'(PAGE_MIN)) && (page_log <= LOG_W'(PAGE_MAX));
        page_code = page_ok ? CODE_W'(page_log - LOG_W'(PAGE_BASE)) : CODE_EMPTY;
        exp_v     = size_log - LOG_W'(SIZE_BASE);
        if (size_log < LOG_W'(SIZE_BASE)) begin
            units = '0;
        end else if (exp_v >= LOG_W'(BND_W)) begin
            units = (BND_W+1)'(1) << BND_W;
        end else begin
            units = (BND_W+1)'(1) << exp_v;
        end
    end
endmodule

// File: rtl/rbd_accum.sv
module rbd_accum
    import rbd_pkg::*;
#(
    parameter int NUM_DIMMS = 2,
    parameter int BND_W     = 8,
    localparam int NUM_RANKS = 2 * NUM_DIMMS,
    localparam int SLOT_W    = $clog2(NUM_DIMMS + 1)
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 cfg_valid,
    input  logic                                 cfg_present,
    input  logic                                 cfg_two_sided,
    input  logic [1:0]                           side_ok,
    input  logic [1:0][CODE_W-1:0]               side_code,
    input  logic [1:0][BND_W:0]                  side_units,
    output logic [NUM_RANKS-1:0][BND_W-1:0]      bnd,
    output logic [NUM_RANKS-1:0][CODE_W-1:0]     code
);
    localparam int SUM_W = BND_W + 2;
    localparam logic [SUM_W-1:0] SAT = SUM_W'((1 << BND_W) - 1);

    typedef struct packed {
        logic [SLOT_W-1:0]                   slot;
        logic [BND_W-1:0]                    total;
        logic [NUM_RANKS-1:0][BND_W-1:0]     bnd;
        logic [NUM_RANKS-1:0][CODE_W-1:0]    code;
    } acc_t;

    acc_t st_d, st_q;

    logic             dimm_ok;
    logic             odd_ok;
    logic [SUM_W-1:0] sum0, sum1;
    logic [BND_W-1:0] t0, t1;

    always_comb begin
        st_d    = st_q;
        dimm_ok = cfg_present && side_ok[0] && (!cfg_two_sided || side_ok[1]);
        odd_ok  = dimm_ok && cfg_two_sided;
        sum0    = SUM_W'(st_q.total) + (dimm_ok ? SUM_W'(side_units[0]) : '0);
        t0      = (sum0 > SAT) ? BND_W'(SAT) : BND_W'(sum0);
        sum1    = SUM_W'(t0) + (odd_ok ? SUM_W'(side_units[1]) : '0);
        t1      = (sum1 > SAT) ? BND_W'(SAT) : BND_W'(sum1);
        if (cfg_valid && (int'(st_q.slot) < NUM_DIMMS)) begin
            for (int r = 0; r < NUM_RANKS; r++) begin
                if (r == 2 * int'(st_q.slot)) begin
                    st_d.bnd[r]  = t0;
                    st_d.code[r] = dimm_ok ? side_code[0] : CODE_EMPTY;
                end else if (r == 2 * int'(st_q.slot) + 1) begin
                    st_d.bnd[r]  = t1;
                    st_d.code[r] = odd_ok ? side_code[1] : CODE_EMPTY;
                end else if (r > 2 * int'(st_q.slot) + 1) begin
                    st_d.bnd[r]  = t1;
                end
            end
            st_d.total = t1;
            st_d.slot  = st_q.slot + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.slot  <= '0;
            st_q.total <= '0;
            for (int r = 0; r < NUM_RANKS; r++) begin
                st_q.bnd[r]  <= '0;
                st_q.code[r] <= CODE_EMPTY;
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign bnd  = st_q.bnd;
    assign code = st_q.code;
endmodule

// File: rtl/rbd_lookup.sv
module rbd_lookup
    import rbd_pkg::*;
#(
    parameter int NUM_RANKS  = 4,
    parameter int BND_W      = 8,
    parameter int ADDR_W     = 32,
    parameter int UNIT_SHIFT = 25,
    localparam int RANK_W = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
    localparam int KEY_W  = ADDR_W - UNIT_SHIFT,
    localparam int CMP_W  = (KEY_W > BND_W) ? KEY_W : BND_W
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 lk_valid,
    input  logic [ADDR_W-1:0]                    lk_addr,
    input  logic [NUM_RANKS-1:0][BND_W-1:0]      bnd,
    input  logic [NUM_RANKS-1:0][CODE_W-1:0]     code,
    output logic                                 res_valid,
    output logic                                 res_hit,
    output logic [RANK_W-1:0]                    res_rank,
    output logic [CODE_W-1:0]                    res_code,
    output logic [ADDR_W-1:0]                    res_base
);
    typedef struct packed {
        logic                valid;
        logic                hit;
        logic [RANK_W-1:0]   rank;
        logic [CODE_W-1:0]   code;
        logic [ADDR_W-1:0]   base;
    } res_t;

    res_t res_d, res_q;

    logic [CMP_W-1:0]                key;
    logic [NUM_RANKS-1:0][BND_W-1:0] prev;
    logic [BND_W-1:0]                sel_prev;

    always_comb begin
        key     = CMP_W'(lk_addr[ADDR_W-1:UNIT_SHIFT]);
        prev[0] = '0;
        for (int r = 1; r < NUM_RANKS; r++) begin
            prev[r] = bnd[r-1];
        end
        res_d       = '0;
        res_d.code  = CODE_EMPTY;
        res_d.valid = lk_valid;
        sel_prev    = '0;
        for (int r = NUM_RANKS - 1; r >= 0; r--) begin
            if (CMP_W'(bnd[r]) > key) begin
                res_d.hit  = 1'b1;
                res_d.rank = RANK_W'(r);
                res_d.code = code[r];
                sel_prev   = prev[r];
            end
        end
        res_d.base = res_d.hit ? (ADDR_W'(sel_prev) << UNIT_SHIFT) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q      <= '0;
            res_q.code <= CODE_EMPTY;
        end else begin
            res_q <= res_d;
        end
    end

    assign res_valid = res_q.valid;
    assign res_hit   = res_q.hit;
    assign res_rank  = res_q.rank;
    assign res_code  = res_q.code;
    assign res_base  = res_q.base;
endmodule

// File: rtl/rank_boundary_decoder.sv
module rank_boundary_decoder
    import rbd_pkg::*;
#(
    parameter int NUM_DIMMS  = 2,
    parameter int BND_W      = 8,
    parameter int ADDR_W     = 32,
    parameter int UNIT_SHIFT = 25,
    localparam int NUM_RANKS = 2 * NUM_DIMMS,
    localparam int RANK_W    = $clog2(NUM_RANKS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_valid,
    input  logic                         cfg_present,
    input  logic                         cfg_two_sided,
    input  logic [2:0]                   cfg_wlog,
    input  logic [1:0]                   cfg_blog,
    input  logic [3:0]                   cfg_col0,
    input  logic [3:0]                   cfg_row0,
    input  logic [3:0]                   cfg_col1,
    input  logic [3:0]                   cfg_row1,
    input  logic                         lk_valid,
    input  logic [ADDR_W-1:0]            lk_addr,
    output logic [NUM_RANKS*BND_W-1:0]   bnd_flat,
    output logic                         res_valid,
    output logic                         res_hit,
    output logic [RANK_W-1:0]            res_rank,
    output logic [2:0]                   res_code,
    output logic [ADDR_W-1:0]            res_base
);
    side_geom_t [1:0]                  geom;
    logic [1:0]                        side_ok;
    logic [1:0][CODE_W-1:0]            side_code;
    logic [1:0][BND_W:0]               side_units;
    logic [NUM_RANKS-1:0][BND_W-1:0]   bnd;
    logic [NUM_RANKS-1:0][CODE_W-1:0]  code;

    assign geom[0] = '{col: cfg_col0, row: cfg_row0};
    assign geom[1] = '{col: cfg_col1, row: cfg_row1};

    for (genvar s = 0; s < 2; s++) begin : g_side
        rbd_side_calc #(.BND_W(BND_W)) u_side (
            .geom      (geom[s]),
            .wlog      (cfg_wlog),
            .blog      (cfg_blog),
            .page_ok   (side_ok[s]),
            .page_code (side_code[s]),
            .units     (side_units[s])
        );
    end

    rbd_accum #(.NUM_DIMMS(NUM_DIMMS), .BND_W(BND_W)) u_accum (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_valid     (cfg_valid),
        .cfg_present   (cfg_present),
        .cfg_two_sided (cfg_two_sided),
        .side_ok       (side_ok),
        .side_code     (side_code),
        .side_units    (side_units),
        .bnd           (bnd),
        .code          (code)
    );

    rbd_lookup #(
        .NUM_RANKS(NUM_RANKS), .BND_W(BND_W),
        .ADDR_W(ADDR_W), .UNIT_SHIFT(UNIT_SHIFT)
    ) u_lookup (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_valid  (lk_valid),
        .lk_addr   (lk_addr),
        .bnd       (bnd),
        .code      (code),
        .res_valid (res_valid),
        .res_hit   (res_hit),
        .res_rank  (res_rank),
        .res_code  (res_code),
        .res_base  (res_base)
    );

    assign bnd_flat = bnd;
endmodule

// File: rtl/rbd_checker.sv
module rbd_checker #(
    parameter int NUM_RANKS = 4,
    parameter int BND_W     = 8,
    parameter int ADDR_W    = 32,
    parameter int RANK_W    = 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         cfg_valid,
    input logic                         lk_valid,
    input logic [NUM_RANKS*BND_W-1:0]   bnd_flat,
    input logic                         res_valid,
    input logic                         res_hit,
    input logic [RANK_W-1:0]            res_rank,
    input logic [2:0]                   res_code,
    input logic [ADDR_W-1:0]            res_base
);
    for (genvar r = 1; r < NUM_RANKS; r++) begin : g_mono
        assert_bnd_monotonic_R4: assert property (@(posedge clk) disable iff (!rst_n)
            bnd_flat[r*BND_W +: BND_W] >= bnd_flat[(r-1)*BND_W +: BND_W]);
    end

    assert_bnd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_valid |=> $stable(bnd_flat));

    assert_result_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);

    assert_no_spurious_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_valid);

    assert_miss_values_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_code == 3'd7 && res_rank == '0 && res_base == '0));

    assert_hit_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_hit) |-> (res_code >= 3'd1 && res_code <= 3'd3));
endmodule

bind rank_boundary_decoder rbd_checker #(
    .NUM_RANKS(NUM_RANKS), .BND_W(BND_W), .ADDR_W(ADDR_W), .RANK_W(RANK_W)
) u_rbd_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_valid (cfg_valid),
    .lk_valid  (lk_valid),
    .bnd_flat  (bnd_flat),
    .res_valid (res_valid),
    .res_hit   (res_hit),
    .res_rank  (res_rank),
    .res_code  (res_code),
    .res_base  (res_base)
);

// File: tb/rank_boundary_decoder_test.sv
module rank_boundary_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_valid = 1'b0, cfg_present = 1'b0, cfg_two_sided = 1'b0;
    logic [2:0]  cfg_wlog = '0;
    logic [1:0]  cfg_blog = '0;
    logic [3:0]  cfg_col0 = '0, cfg_row0 = '0, cfg_col1 = '0, cfg_row1 = '0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic [31:0] bnd_flat;
    logic        res_valid, res_hit;
    logic [1:0]  res_rank;
    logic [2:0]  res_code;
    logic [31:0] res_base;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rank_boundary_decoder uut (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_present(cfg_present),
        .cfg_two_sided(cfg_two_sided), .cfg_wlog(cfg_wlog), .cfg_blog(cfg_blog),
        .cfg_col0(cfg_col0), .cfg_row0(cfg_row0), .cfg_col1(cfg_col1), .cfg_row1(cfg_row1),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .bnd_flat(bnd_flat), .res_valid(res_valid),
        .res_hit(res_hit), .res_rank(res_rank), .res_code(res_code), .res_base(res_base)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic        hit;
        logic [1:0]  rank;
        logic [2:0]  code;
        logic [31:0] base;
    } vec_t;

    // Scenario A boundaries {8,12,20,20}, codes {2,1,3,7}
    localparam vec_t TBL [8] = '{
        '{32'h0000_0000, 1'b1, 2'd0, 3'd2, 32'h0000_0000},
        '{32'h0E00_0000, 1'b1, 2'd0, 3'd2, 32'h0000_0000},
        '{32'h1000_0000, 1'b1, 2'd1, 3'd1, 32'h1000_0000},
        '{32'h17FF_FFFF, 1'b1, 2'd1, 3'd1, 32'h1000_0000},
        '{32'h1800_0000, 1'b1, 2'd2, 3'd3, 32'h1800_0000},
        '{32'h27FF_FFFF, 1'b1, 2'd2, 3'd3, 32'h1800_0000},
        '{32'h2800_0000, 1'b0, 2'd0, 3'd7, 32'h0000_0000},
        '{32'hFE00_0000, 1'b0, 2'd0, 3'd7, 32'h0000_0000}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send_cfg(input logic pres, input logic two, input logic [2:0] wl,
                            input logic [1:0] bl, input logic [3:0] c0, input logic [3:0] r0,
                            input logic [3:0] c1, input logic [3:0] r1);
        @(negedge clk);
        cfg_valid = 1'b1; cfg_present = pres; cfg_two_sided = two;
        cfg_wlog = wl; cfg_blog = bl;
        cfg_col0 = c0; cfg_row0 = r0; cfg_col1 = c1; cfg_row1 = r1;
        @(negedge clk);
        cfg_valid = 1'b0;
    endtask

    task automatic lookup(input string req, input logic [31:0] a, input logic hit,
                          input logic [1:0] rank, input logic [2:0] code, input logic [31:0] base);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a;
        @(negedge clk);
        lk_valid = 1'b0;
        check({req, " valid"}, 64'(res_valid), 64'(1'b1));
        check({req, " hit"},   64'(res_hit),   64'(hit));
        check({req, " rank"},  64'(res_rank),  64'(rank));
        check({req, " code"},  64'(res_code),  64'(code));
        check({req, " base"},  64'(res_base),  64'(base));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        check("R1 bnd after reset", 64'(bnd_flat), 64'h0);
        lookup("R1 lookup after reset", 32'h0000_0000, 1'b0, 2'd0, 3'd7, 32'h0);

        // Scenario A: slot0 two-sided 8+4 units, slot1 single-sided 8 units
        send_cfg(1'b1, 1'b1, 3'd6, 2'd2, 4'd10, 4'd13, 4'd9, 4'd13);
        // R5: unloaded ranks hold running total
        check("R5 partial load", 64'(bnd_flat), 64'h0C0C_0C08);
        send_cfg(1'b1, 1'b0, 3'd6, 2'd2, 4'd11, 4'd12, 4'd0, 4'd0);
        check("R3 R4 R2 boundaries", 64'(bnd_flat), 64'h1414_0C08);

        for (int i = 0; i < 8; i++) begin
            lookup("R8 R9 R10 R6 R7 table", TBL[i].addr, TBL[i].hit, TBL[i].rank,
                   TBL[i].code, TBL[i].base);
        end

        // R2: extra entry ignored
        send_cfg(1'b1, 1'b1, 3'd6, 2'd3, 4'd11, 4'd15, 4'd11, 4'd15);
        check("R2 extra cfg ignored", 64'(bnd_flat), 64'h1414_0C08);
        lookup("R2 decode after extra cfg", 32'h1000_0000, 1'b1, 2'd1, 3'd1, 32'h1000_0000);
        // R11: idle cycles keep boundaries
        repeat (3) @(negedge clk);
        check("R11 hold", 64'(bnd_flat), 64'h1414_0C08);

        // Scenario B: slot0 second side page 2^18 drops module; slot1 single 16 units
        do_reset();
        send_cfg(1'b1, 1'b1, 3'd6, 2'd2, 4'd10, 4'd13, 4'd12, 4'd13);
        check("R6 unsupported page drops module", 64'(bnd_flat), 64'h0);
        send_cfg(1'b1, 1'b0, 3'd6, 2'd2, 4'd10, 4'd14, 4'd0, 4'd0);
        check("R5 single side", 64'(bnd_flat), 64'h1010_0000);
        lookup("R6 R8 skip empty ranks", 32'h0000_0000, 1'b1, 2'd2, 3'd2, 32'h0);
        lookup("R9 at last boundary", 32'h2000_0000, 1'b0, 2'd0, 3'd7, 32'h0);

        // Scenario C: slot0 absent, slot1 two-sided 128+128 saturating
        do_reset();
        send_cfg(1'b0, 1'b1, 3'd6, 2'd2, 4'd10, 4'd13, 4'd10, 4'd13);
        check("R5 absent module", 64'(bnd_flat), 64'h0);
        send_cfg(1'b1, 1'b1, 3'd6, 2'd3, 4'd11, 4'd15, 4'd11, 4'd15);
        check("R4 saturation", 64'(bnd_flat), 64'hFF80_0000);
        lookup("R10 R8 top key", 32'hFE00_0000, 1'b1, 2'd2, 3'd3, 32'h0);

        // Scenario D: page 2^14 too small, and log2 size below 28 gives 0 units
        do_reset();
        send_cfg(1'b1, 1'b0, 3'd6, 2'd2, 4'd8, 4'd15, 4'd0, 4'd0);
        check("R6 page too small", 64'(bnd_flat), 64'h0);
        send_cfg(1'b1, 1'b0, 3'd6, 2'd0, 4'd9, 4'd12, 4'd0, 4'd0);
        check("R3 sub-unit size", 64'(bnd_flat), 64'h0);
        lookup("R7 empty ranks miss", 32'h0000_0000, 1'b0, 2'd0, 3'd7, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule